// File: doc/BRIEF.md
# Carry-Bubble Wide Adder

This block adds two wide operands that are split into F fields of W bits each (by default four fields of 64 bits). Every field is summed independently and in parallel, dropping its own carry. The carries that cross field boundaries are then settled in constant depth. Each field contributes one "generate" bit, derived from the top bits of the operands and of its raw sum. Each field also contributes one "bubble" bit, set when its raw sum is all ones. A marker-advance operation, one narrow add plus bitwise logic over F+1 bits, turns these two masks and the carry-in into a per-field increment mask. Each field of the raw sum is then incremented by its bit of that mask, and the bit above the top field is the carry-out.

The carry-in and carry-out let instances be chained, or arranged in two levels to reach operand widths of W times W bits. A build-time parameter of enumerated type selects the variant. `STAGE_COMB` gives a purely combinational adder. `STAGE_REG` gives a one-stage version whose sum and carry-out are registered and clear on an asynchronous active-low reset. There is no sequencing state: the only "states" are the two variants, and the only transition is reset release, after which the registered variant loads a new result on every clock.

Top module: `cbadd_top`

## Requirements
- R1: The sum output equals (opnd_a + opnd_b + cin) modulo 2^(F*W), where field k occupies bits [k*W+W-1 : k*W] and field 0 is least significant.
- R2: cout equals bit F*W of the full-width value opnd_a + opnd_b + cin.
- R3: When every field of the raw field sum is all ones, a carry-in of 1 runs through all fields: the sum is zero and cout is 1.
- R4: A carry produced by field k passes through consecutive all-ones fields above it, clearing them, and increments the first field above them that is not all ones.
- R5: With cin 0 and no field producing a carry, each field of the sum equals the W-bit sum of the matching operand fields.
- R6: With STAGE_REG, sum and cout present the result of the inputs sampled at the previous rising clock edge.
- R7: With STAGE_REG, while rst_n is low, sum and cout are zero.
- R8: With STAGE_COMB, F=8 and W=8, operands 0x1931BA4C3D4521F1 and 0x221245B3E2161736 with cin 0 give sum 0x3B4400001F5B3927 and cout 0, in the same cycle as the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered variant |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| opnd_a | input | F*W | First operand, field 0 in the low bits |
| opnd_b | input | F*W | Second operand, field 0 in the low bits |
| cin | input | 1 | Carry into field 0 |
| sum | output | F*W | Sum modulo 2^(F*W) |
| cout | output | 1 | Carry out of the top field |

## Verification
The hardest case to reach from the ports is a carry that crosses several all-ones fields. Random operands almost never make a W-bit field sum to exactly all ones, so a random run hardly exercises the bubble path. The bench therefore builds operands field by field. It places one field that generates a carry under a run of fields whose raw sums are all ones, and it sets every field to all ones with a carry-in. It also runs the 8-field, 8-bit example, where a bubble field sits between two carries.

// File: rtl/cbadd_pkg.sv
package cbadd_pkg;
    typedef enum logic [0:0] {
        STAGE_COMB = 1'b0,
        STAGE_REG  = 1'b1
    } stage_e;
endpackage

// File: rtl/cbadd_fields.sv
module cbadd_fields #(
    parameter int F = 4,
    parameter int W = 64
) (
    input  logic [F*W-1:0] a,
    input  logic [F*W-1:0] b,
    output logic [F*W-1:0] raw,
    output logic [F-1:0]   top_a,
    output logic [F-1:0]   top_b,
    output logic [F-1:0]   top_r,
    output logic [F-1:0]   bubble
);
    for (genvar k = 0; k < F; k++) begin : g_field
        logic [W-1:0] fa;
        logic [W-1:0] fb;
        logic [W-1:0] fr;
        assign fa = a[k*W +: W];
        assign fb = b[k*W +: W];
        assign fr = fa + fb;
        assign raw[k*W +: W] = fr;
        assign top_a[k]  = fa[W-1];
        assign top_b[k]  = fb[W-1];
        assign top_r[k]  = fr[W-1];
        assign bubble[k] = &fr;
    end
endmodule

// File: rtl/cbadd_star.sv
module cbadd_star #(
    parameter int L = 5
) (
    input  logic [L-1:0] marker,
    input  logic [L-1:0] cls,
    output logic [L-1:0] reach
);
    logic [L-1:0] seed;
    logic [L-1:0] advanced;
    always_comb begin
        seed     = marker & cls;
        advanced = seed + cls;
        reach    = (advanced ^ cls) | marker;
    end
endmodule

// File: rtl/cbadd_spread.sv
module cbadd_spread #(
    parameter int F = 4,
    parameter int W = 64
) (
    input  logic [F*W-1:0] raw,
    input  logic [F-1:0]   inc,
    output logic [F*W-1:0] sum
);
    for (genvar k = 0; k < F; k++) begin : g_inc
        assign sum[k*W +: W] = raw[k*W +: W] + {{(W-1){1'b0}}, inc[k]};
    end
endmodule

// File: rtl/cbadd_top.sv
module cbadd_top
    import cbadd_pkg::*;
#(
    parameter int     F     = 4,
    parameter int     W     = 64,
    parameter stage_e STAGE = STAGE_REG
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [F*W-1:0] opnd_a,
    input  logic [F*W-1:0] opnd_b,
    input  logic           cin,
    output logic [F*W-1:0] sum,
    output logic           cout
);
    localparam int N = F * W;
    localparam int L = F + 1;

    logic [N-1:0] raw_sum;
    logic [F-1:0] top_a, top_b, top_r, bubble;
    logic [F-1:0] gen_mask;
    logic [L-1:0] marker, cls, inc_mask;
    logic [N-1:0] sum_c;
    logic         cout_c;

    cbadd_fields #(.F(F), .W(W)) u_fields (
        .a(opnd_a), .b(opnd_b), .raw(raw_sum),
        .top_a(top_a), .top_b(top_b), .top_r(top_r), .bubble(bubble)
    );

    always_comb begin
        gen_mask = (top_a & top_b) | ((top_a | top_b) & ~top_r);
        marker   = {gen_mask, cin};
        cls      = {1'b0, bubble};
    end

    cbadd_star #(.L(L)) u_star (
        .marker(marker), .cls(cls), .reach(inc_mask)
    );

    cbadd_spread #(.F(F), .W(W)) u_spread (
        .raw(raw_sum), .inc(inc_mask[F-1:0]), .sum(sum_c)
    );

    assign cout_c = inc_mask[F];

    if (STAGE == STAGE_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sum  <= '0;
                cout <= 1'b0;
            end else begin
                sum  <= sum_c;
                cout <= cout_c;
            end
        end
    end else begin : g_comb
        always_comb begin
            sum  = sum_c;
            cout = cout_c;
        end
    end
endmodule

// File: rtl/cbadd_chk.sv
module cbadd_chk
    import cbadd_pkg::*;
#(
    parameter int     F     = 4,
    parameter int     W     = 64,
    parameter stage_e STAGE = STAGE_REG
) (
    input logic           clk,
    input logic           rst_n,
    input logic [F*W-1:0] opnd_a,
    input logic [F*W-1:0] opnd_b,
    input logic           cin,
    input logic [F*W-1:0] sum,
    input logic           cout,
    input logic [F*W-1:0] raw_sum,
    input logic [F-1:0]   gen_mask
);
    localparam int N = F * W;
    logic [N:0] ref_full;
    assign ref_full = {1'b0, opnd_a} + {1'b0, opnd_b} + {{N{1'b0}}, cin};

    if (STAGE == STAGE_REG) begin : g_reg
        assert_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> sum == $past(ref_full[N-1:0]));
        assert_cout_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> cout == $past(ref_full[N]));
        assert_clear_R7: assert property (@(posedge clk)
            !rst_n |-> (sum == '0 && !cout));
        assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(cin) && $past(gen_mask) == '0)
            |-> sum == $past(raw_sum));
    end else begin : g_comb
        assert_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
            sum == ref_full[N-1:0]);
        assert_cout_R2: assert property (@(posedge clk) disable iff (!rst_n)
            cout == ref_full[N]);
        assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!cin && gen_mask == '0) |-> sum == raw_sum);
        assert_nocarry_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!cin && gen_mask == '0) |-> !cout);
    end
endmodule

bind cbadd_top cbadd_chk #(.F(F), .W(W), .STAGE(STAGE)) u_chk (
    .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b), .cin(cin),
    .sum(sum), .cout(cout), .raw_sum(raw_sum), .gen_mask(gen_mask)
);

// File: tb/cbadd_top_test.sv
module cbadd_top_test;
    import cbadd_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int F = 4;
    localparam int W = 64;
    localparam int N = F * W;
    localparam int SF = 8;
    localparam int SW = 8;
    localparam int SN = SF * SW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] a = '0, b = '0;
    logic cin = 1'b0;
    logic [N-1:0] s;
    logic co;
    logic [SN-1:0] sa = '0, sb = '0;
    logic scin = 1'b0;
    logic [SN-1:0] ss;
    logic sco;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cbadd_top #(.F(F), .W(W), .STAGE(STAGE_REG)) uut (
        .clk(clk), .rst_n(rst_n), .opnd_a(a), .opnd_b(b), .cin(cin),
        .sum(s), .cout(co)
    );

    cbadd_top #(.F(SF), .W(SW), .STAGE(STAGE_COMB)) uut_small (
        .clk(clk), .rst_n(rst_n), .opnd_a(sa), .opnd_b(sb), .cin(scin),
        .sum(ss), .cout(sco)
    );

    task automatic check(input string tag, input logic [N:0] got, input logic [N:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // drive at negedge, registered result visible at the following negedge
    task automatic apply(input logic [N-1:0] xa, input logic [N-1:0] xb, input logic xc);
        @(negedge clk);
        a = xa; b = xb; cin = xc;
        @(negedge clk);
    endtask

    task automatic check_full(input string tag);
        logic [N:0] ref_v;
        ref_v = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin};
        check({tag, " sum"}, {1'b0, s}, {1'b0, ref_v[N-1:0]});
        check({tag, " cout"}, {{N{1'b0}}, co}, {{N{1'b0}}, ref_v[N]});
    endtask

    task automatic t_reset;
        @(negedge clk);
        a = '1; b = '1; cin = 1'b1;
        @(negedge clk);
        check("R7 reset clear", {co, s}, '0);
        rst_n = 1'b1;
    endtask

    task automatic t_latency;
        logic [N-1:0] prev;
        apply({N{1'b0}} | 64'd7, {N{1'b0}} | 64'd9, 1'b0);
        check("R6 loaded", {co, s}, {1'b0, {N{1'b0}} | 64'd16});
        @(negedge clk);
        prev = s;
        a = {N{1'b0}} | 64'd100; b = '0; cin = 1'b0;
        #1;
        check("R6 holds before edge", {co, s}, {1'b0, prev});
        @(negedge clk);
        check("R6 after edge", {co, s}, {1'b0, {N{1'b0}} | 64'd100});
    endtask

    task automatic t_random;
        for (int n = 0; n < 200; n++) begin
            logic [N-1:0] ra, rb;
            for (int j = 0; j < N/32; j++) begin
                ra[j*32 +: 32] = $urandom;
                rb[j*32 +: 32] = $urandom;
            end
            apply(ra, rb, 1'($urandom));
            check_full("R1 R2 random");
        end
    endtask

    task automatic t_all_ones;
        apply('1, '0, 1'b1);
        check("R3 chain sum", {1'b0, s}, '0);
        check("R3 chain cout", {{N{1'b0}}, co}, {{N{1'b0}}, 1'b1});
        apply('1, '1, 1'b1);
        check_full("R3 ones plus ones");
        apply('1, '0, 1'b0);
        check("R3 no cin", {co, s}, {1'b0, {N{1'b1}}});
    endtask

    task automatic t_bubble_run;
        logic [N-1:0] xa, xb, exp;
        xa = '0; xb = '0; exp = '0;
        xa[0*W +: W] = {1'b1, {(W-1){1'b0}}};
        xb[0*W +: W] = {1'b1, {(W-1){1'b0}}};
        xa[1*W +: W] = '1;
        xa[2*W +: W] = {(W/2){2'b01}};
        xb[2*W +: W] = {(W/2){2'b10}};
        xa[3*W +: W] = 64'd5;
        exp[3*W +: W] = 64'd6;
        apply(xa, xb, 1'b0);
        check("R4 carry through bubbles", {co, s}, {1'b0, exp});
        check_full("R4 vs wide add");
        xa[3*W +: W] = '1;
        apply(xa, xb, 1'b0);
        check("R4 carry to cout", {co, s}, {1'b1, {N{1'b0}}});
        for (int k = 0; k < F; k++) begin
            xa = '1; xb = '0;
            xa[k*W +: W] = {1'b1, {(W-1){1'b0}}};
            xb[k*W +: W] = {1'b1, 63'd3};
            apply(xa, xb, 1'b0);
            check_full("R4 generate at each field");
        end
    endtask

    task automatic t_no_carry;
        logic [N-1:0] xa, xb, exp;
        for (int k = 0; k < F; k++) begin
            xa[k*W +: W] = 64'h1111_2222_3333_0000 + 64'(k);
            xb[k*W +: W] = 64'h0101_0202_0303_0404;
            exp[k*W +: W] = 64'h1212_2424_3636_0404 + 64'(k);
        end
        apply(xa, xb, 1'b0);
        check("R5 independent fields", {co, s}, {1'b0, exp});
    endtask

    task automatic t_example;
        @(negedge clk);
        sa = 64'h1931BA4C3D4521F1;
        sb = 64'h221245B3E2161736;
        scin = 1'b0;
        #1;
        check("R8 example sum", {{(N-SN){1'b0}}, 1'b0, ss},
              {{(N-SN){1'b0}}, 1'b0, 64'h3B4400001F5B3927});
        check("R8 example cout", {{N{1'b0}}, sco}, '0);
        sa = '1; sb = '0; scin = 1'b1;
        #1;
        check("R8 comb chain", {{(N-SN){1'b0}}, sco, ss}, {{(N-SN){1'b0}}, 1'b1, {SN{1'b0}}});
    endtask

    initial begin
        t_reset();
        t_latency();
        t_example();
        t_no_carry();
        t_all_ones();
        t_bubble_run();
        t_random();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule